// File: doc/BRIEF.md
# Non-volatile slot store controller

This block sequences every access to a small bank of preset words for a digitally controlled potentiometer. Each slot holds one 9-bit word: an 8-bit tap position in bits 7..0 and a buffer-mode flag in bit 8. The bank is modelled as a register array. Every operation runs for a programmable number of system clock cycles, which stands in for the internal access time of a real non-volatile array.

A host issues one request at a time as a single-cycle valid pulse. The request carries a 4-bit opcode, a 2-bit slot index and 9 bits of data. The block acknowledges a request it accepts and stays busy until the operation finishes. When the operation finishes it pulses done. Depending on the opcode it also updates the readback word or presents a word to be loaded into the tap register.

Programming can only clear bits, so a slot must be erased before it can take an arbitrary value. A low level on the write-protect pin freezes the slot contents but still lets slots be read and loaded. After reset the block recalls slot 0 into the tap register on its own. A dedicated opcode repeats that recall on demand.

Top module: `nv_slot_ctrl`

## Requirements
- R1: While reset is high and after it falls, busy is 1 and ack, done and load_valid are 0; rd_data resets to 0. The block then recalls slot 0: ACCESS_CYCLES cycles after reset falls, done and load_valid pulse with load_data equal to slot 0. Every slot holds 0x1FF at time zero.
- R2: A request is accepted only when busy is 0 and the opcode is one of the seven listed in R3. An accepted request gives a one-cycle ack pulse in the cycle after the request. A request made while busy, or with any other opcode, gets no ack and has no effect.
- R3: Opcodes 1101 (erase), 0010 (program with data) and 0011 (program from tap) keep busy high for STORE_CYCLES cycles after acceptance. Opcodes 1010 (read slot), 1011 (load slot), 1100 (read tap) and 1001 (recall default) keep busy high for ACCESS_CYCLES cycles. done pulses for exactly one cycle in the cycle in which busy falls.
- R4: Erase sets the selected slot to 0x1FF. req_slot values 0 to 3 select slots 0 to 3.
- R5: Program with data sets the slot to the old value ANDed with req_data.
- R6: Program from tap sets the slot to the old value ANDed with tap_value, where tap_value is sampled in the request cycle.
- R7: Read slot places the slot value on rd_data in the done cycle.
- R8: Read tap places the tap_value sampled in the request cycle on rd_data in the done cycle.
- R9: Load slot pulses load_valid with done and puts the slot value on load_data. Recall (1001) does the same for slot 0, whatever req_slot holds.
- R10: If wp_n is 0 in the request cycle, erase and both program operations still run their full timing and pulse done, but the slot is left unchanged. Reads and loads behave the same whether wp_n is high or low.
- R11: rd_data changes only in the done cycle of a read. load_valid pulses only for load and recall operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 4 | Operation code |
| req_slot | input | 2 | Slot index |
| req_data | input | 9 | Data word for program with data |
| tap_value | input | 9 | Current tap register and buffer-mode bit |
| wp_n | input | 1 | Write protect, active low |
| ack | output | 1 | Request accepted pulse |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished pulse |
| rd_data | output | 9 | Readback word |
| load_valid | output | 1 | Load word for the tap register is valid |
| load_data | output | 9 | Word to load into the tap register |

## Verification
The assertions assume that the host keeps req_valid low while busy is high, except for deliberate rejection tests, and that STORE_CYCLES and ACCESS_CYCLES are both at least 2. The bench applies each request for exactly one cycle at a negative edge and then waits for done before it issues the next one. The only exceptions are a few directed pokes made during busy, whose rejection is then checked through later reads. The random mix draws opcodes only from the seven legal codes plus one illegal code, and it toggles wp_n per request.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam logic [3:0] OP_ERASE     = 4'b1101;
  localparam logic [3:0] OP_PROG_DATA = 4'b0010;
  localparam logic [3:0] OP_PROG_TAP  = 4'b0011;
  localparam logic [3:0] OP_READ_SLOT = 4'b1010;
  localparam logic [3:0] OP_LOAD_SLOT = 4'b1011;
  localparam logic [3:0] OP_READ_TAP  = 4'b1100;
  localparam logic [3:0] OP_RECALL    = 4'b1001;

  function automatic logic op_is_store(input logic [3:0] op);
    return (op == OP_ERASE) || (op == OP_PROG_DATA) || (op == OP_PROG_TAP);
  endfunction

  function automatic logic op_is_legal(input logic [3:0] op);
    return op_is_store(op) || (op == OP_READ_SLOT) || (op == OP_LOAD_SLOT) ||
           (op == OP_READ_TAP) || (op == OP_RECALL);
  endfunction
endpackage

// File: rtl/nvs_slot_array.sv
module nvs_slot_array #(
  parameter int WORD_W = 9,
  parameter int SLOTS  = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SLOT_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [SLOTS];

  initial begin
    for (int i = 0; i < SLOTS; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int CNT_W    = 8,
  parameter int RST_LOAD = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= CNT_W'(RST_LOAD);
    else if (start)     cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nvs_sequencer.sv
module nvs_sequencer
  import nvs_pkg::*;
#(
  parameter int WORD_W        = 9,
  parameter int SLOTS         = 4,
  parameter int STORE_CYCLES  = 500000,
  parameter int ACCESS_CYCLES = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int MAXC   = (STORE_CYCLES > ACCESS_CYCLES) ? STORE_CYCLES : ACCESS_CYCLES,
  localparam int CNT_W  = $clog2(MAXC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [WORD_W-1:0] req_data,
  input  logic [WORD_W-1:0] tap_value,
  input  logic              wp_n,
  input  logic              tmr_zero,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tmr_start,
  output logic [CNT_W-1:0]  tmr_load,
  output logic              mem_we,
  output logic [SLOT_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              ack,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rd_data,
  output logic              load_valid,
  output logic [WORD_W-1:0] load_data
);
  logic [3:0]        op_q;
  logic [SLOT_W-1:0] slot_q;
  logic [WORD_W-1:0] data_q, tap_q;
  logic              wp_ok_q;
  logic              finish;

  assign finish    = busy && tmr_zero;
  assign tmr_start = !busy && req_valid && op_is_legal(req_op);
  assign tmr_load  = op_is_store(req_op) ? CNT_W'(STORE_CYCLES - 1) : CNT_W'(ACCESS_CYCLES - 1);
  assign mem_addr  = slot_q;
  assign mem_we    = finish && op_is_store(op_q) && wp_ok_q;

  always_comb begin
    if (op_q == OP_ERASE)        mem_wdata = '1;
    else if (op_q == OP_PROG_TAP) mem_wdata = mem_rdata & tap_q;
    else                          mem_wdata = mem_rdata & data_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b1;
      op_q       <= OP_RECALL;
      slot_q     <= '0;
      data_q     <= '0;
      tap_q      <= '0;
      wp_ok_q    <= 1'b1;
      ack        <= 1'b0;
      done       <= 1'b0;
      load_valid <= 1'b0;
      rd_data    <= '0;
      load_data  <= '0;
    end else begin
      ack        <= 1'b0;
      done       <= 1'b0;
      load_valid <= 1'b0;
      if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
        case (op_q)
          OP_READ_SLOT: rd_data <= mem_rdata;
          OP_READ_TAP:  rd_data <= tap_q;
          OP_LOAD_SLOT, OP_RECALL: begin
            load_valid <= 1'b1;
            load_data  <= mem_rdata;
          end
          default: ;
        endcase
      end else if (tmr_start) begin
        ack     <= 1'b1;
        busy    <= 1'b1;
        op_q    <= req_op;
        slot_q  <= (req_op == OP_RECALL) ? '0 : req_slot;
        data_q  <= req_data;
        tap_q   <= tap_value;
        wp_ok_q <= wp_n;
      end
    end
  end

  // R10: a protected store never writes the array
  p_wp_blocks_write_r10: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wp_ok_q && op_is_store(op_q));
  // R9: a load strobe always comes with done
  p_load_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    load_valid |-> done);
  // R11: rd_data only moves together with done
  p_rd_stable_r11: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rd_data));
endmodule

// File: rtl/nv_slot_ctrl.sv
module nv_slot_ctrl #(
  parameter int WORD_W        = 9,
  parameter int SLOTS         = 4,
  parameter int STORE_CYCLES  = 500000,
  parameter int ACCESS_CYCLES = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int MAXC   = (STORE_CYCLES > ACCESS_CYCLES) ? STORE_CYCLES : ACCESS_CYCLES,
  localparam int CNT_W  = $clog2(MAXC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [WORD_W-1:0] req_data,
  input  logic [WORD_W-1:0] tap_value,
  input  logic              wp_n,
  output logic              ack,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rd_data,
  output logic              load_valid,
  output logic [WORD_W-1:0] load_data
);
  logic              tmr_start, tmr_zero, mem_we;
  logic [CNT_W-1:0]  tmr_load;
  logic [SLOT_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_wdata, mem_rdata;

  initial begin
    if (STORE_CYCLES < 2 || ACCESS_CYCLES < 2)
      $error("operation latencies must be at least 2 cycles");
  end

  nvs_sequencer #(
    .WORD_W(WORD_W), .SLOTS(SLOTS),
    .STORE_CYCLES(STORE_CYCLES), .ACCESS_CYCLES(ACCESS_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_slot(req_slot), .req_data(req_data), .tap_value(tap_value),
    .wp_n(wp_n), .tmr_zero(tmr_zero), .mem_rdata(mem_rdata),
    .tmr_start(tmr_start), .tmr_load(tmr_load), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ack(ack), .busy(busy),
    .done(done), .rd_data(rd_data), .load_valid(load_valid),
    .load_data(load_data)
  );

  nvs_timer #(.CNT_W(CNT_W), .RST_LOAD(ACCESS_CYCLES - 1)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_start), .load_val(tmr_load), .zero(tmr_zero)
  );

  nvs_slot_array #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );

  // R3: busy and done never overlap
  p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  // R3: busy falling is always the done cycle
  p_fall_is_done_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R2: an ack only follows an idle cycle and starts busy
  p_ack_idle_r2: assert property (@(posedge clk) disable iff (rst)
    ack |-> busy && !$past(busy));
  // R3: done lasts a single cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/tb_nv_slot_ctrl.sv
`timescale 1ns/1ps
module tb_nv_slot_ctrl;
  localparam int SC = 12;
  localparam int AC = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [3:0] req_op = '0;
  logic [1:0] req_slot = '0;
  logic [8:0] req_data = '0;
  logic [8:0] tap_value = '0;
  logic       wp_n = 1'b1;
  logic       ack, busy, done, load_valid;
  logic [8:0] rd_data, load_data;

  int checks = 0;
  int fails  = 0;
  logic [8:0] exp_mem [4];
  logic [8:0] exp_rd = '0;

  always #2 clk = ~clk;

  nv_slot_ctrl #(.STORE_CYCLES(SC), .ACCESS_CYCLES(AC)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_slot(req_slot), .req_data(req_data), .tap_value(tap_value),
    .wp_n(wp_n), .ack(ack), .busy(busy), .done(done), .rd_data(rd_data),
    .load_valid(load_valid), .load_data(load_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_store(input logic [3:0] op);
    return op == 4'b1101 || op == 4'b0010 || op == 4'b0011;
  endfunction

  function automatic bit is_legal(input logic [3:0] op);
    return is_store(op) || op == 4'b1010 || op == 4'b1011 || op == 4'b1100 || op == 4'b1001;
  endfunction

  function automatic logic [8:0] next_val(input logic [3:0] op, input logic [8:0] old,
                                          input logic [8:0] d, input logic [8:0] t);
    if (op == 4'b1101) return 9'h1FF;
    if (op == 4'b0010) return old & d;
    return old & t;
  endfunction

  task automatic do_op(input logic [3:0] op, input logic [1:0] slot,
                       input logic [8:0] d, input logic [8:0] t, input logic w);
    int lat;
    logic [1:0] s;
    logic [8:0] cur;
    s   = (op == 4'b1001) ? 2'd0 : slot;
    cur = exp_mem[s];
    req_valid = 1'b1; req_op = op; req_slot = slot; req_data = d; tap_value = t; wp_n = w;
    @(negedge clk);
    req_valid = 1'b0;
    tap_value = ~t;
    wp_n = ~w;
    if (!is_legal(op)) begin
      check("R2 illegal no ack", ack, 0);
      check("R2 illegal idle", busy, 0);
      return;
    end
    check("R2 ack", ack, 1);
    check("R3 busy start", busy, 1);
    lat = is_store(op) ? SC : AC;
    repeat (lat - 1) @(negedge clk);
    check("R3 busy last", {busy, done}, 2'b10);
    @(negedge clk);
    check("R3 done", {busy, done}, 2'b01);
    if (op == 4'b1010) exp_rd = cur;
    if (op == 4'b1100) exp_rd = t;
    check("R7 R8 R11 rd_data", rd_data, exp_rd);
    check("R9 R11 load_valid", load_valid, (op == 4'b1011 || op == 4'b1001));
    if (op == 4'b1011 || op == 4'b1001) check("R9 load_data", load_data, cur);
    if (is_store(op) && w) exp_mem[s] = next_val(op, cur, d, t);
    @(negedge clk);
    check("R3 done one cycle", done, 0);
  endtask

  task automatic read_back(input logic [1:0] s, input string req);
    do_op(4'b1010, s, 9'h0, 9'h0, 1'b1);
    check(req, rd_data, exp_mem[s]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) exp_mem[i] = 9'h1FF;
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy, 1);
    check("R1 reset pulses", {ack, done, load_valid}, 3'b000);
    check("R1 reset rd_data", rd_data, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 boot busy", busy, 1);
    repeat (AC - 2) @(negedge clk);
    check("R1 boot still busy", busy, 1);
    @(negedge clk);
    check("R1 boot done", {done, load_valid}, 2'b11);
    check("R1 boot load slot0", load_data, 9'h1FF);
    @(negedge clk);

    // directed corners
    do_op(4'b0010, 2'd1, 9'h0A5, 9'h0, 1'b1);
    read_back(2'd1, "R5 program AND");
    do_op(4'b0010, 2'd1, 9'h1F0, 9'h0, 1'b1);
    read_back(2'd1, "R5 program only clears");
    do_op(4'b1101, 2'd1, 9'h0, 9'h0, 1'b0);
    read_back(2'd1, "R10 protected erase no change");
    do_op(4'b1101, 2'd1, 9'h0, 9'h0, 1'b1);
    read_back(2'd1, "R4 erase to ones");
    do_op(4'b0011, 2'd3, 9'h0, 9'h13C, 1'b1);
    read_back(2'd3, "R6 program from tap");
    do_op(4'b0010, 2'd3, 9'h000, 9'h0, 1'b0);
    read_back(2'd3, "R10 protected program no change");
    do_op(4'b1011, 2'd3, 9'h0, 9'h0, 1'b0);
    check("R10 load under protect", load_data, 9'h13C);
    do_op(4'b1100, 2'd2, 9'h0, 9'h0C3, 1'b1);
    check("R8 read tap", rd_data, 9'h0C3);
    do_op(4'b0010, 2'd0, 9'h155, 9'h0, 1'b1);
    do_op(4'b1001, 2'd3, 9'h0, 9'h0, 1'b1);
    check("R9 recall slot0", load_data, 9'h155);
    do_op(4'b0000, 2'd2, 9'h0, 9'h0, 1'b1);
    @(negedge clk);
    check("R11 rd_data held after illegal", rd_data, exp_rd);

    // R2: request during busy is rejected and leaves no trace
    req_valid = 1'b1; req_op = 4'b1010; req_slot = 2'd2; wp_n = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 ack on accept", ack, 1);
    @(negedge clk);
    req_valid = 1'b1; req_op = 4'b0010; req_slot = 2'd2; req_data = 9'h000;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 busy request no ack", ack, 0);
    repeat (AC) @(negedge clk);
    check("R2 busy request idle after", busy, 0);
    read_back(2'd2, "R2 busy request no effect");

    // constrained random mix
    for (int n = 0; n < 80; n++) begin
      logic [3:0] ops [8];
      logic [3:0] op;
      ops = '{4'b1101, 4'b0010, 4'b0011, 4'b1010, 4'b1011, 4'b1100, 4'b1001, 4'b0111};
      op = ops[$urandom_range(0, 7)];
      do_op(op, 2'($urandom_range(0, 3)), 9'($urandom), 9'($urandom),
            1'($urandom_range(0, 3) != 0));
    end
    for (int s = 0; s < 4; s++) read_back(2'(s), "R4 R5 R6 R10 final contents");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule